// File: doc/BRIEF.md
# Self-Describing Bus Table Scanner

This block is a bus master that walks a self-description table held in bus memory. A start pulse launches the scan at an externally supplied base address. The header record there is checked for its identifying magic word, its format version and its bus type. The block then steps through the fixed 64-byte records that follow the header. For every record that describes something, it emits one beat on a valid/ready stream. The beat carries the record's type code, its base address, the address range of the component it describes, and the nesting depth at which it was found.

A bridge record is reported first. The scanner then descends into the nested table, which sits at the bridge's start address plus the child offset stored in the bridge. That nested table is checked exactly like the top-level one, and the parent walk resumes once it is exhausted. Nesting is held on a four-deep return stack.

The memory side is a 32-bit read-only request/acknowledge master. Multi-byte fields are big-endian: the byte at the lowest address sits in bits 31:24 of a word. The scanner fetches only the words of the current table that it needs, and never reads past the record count. A finished scan raises `done`. A malformed table raises `done` together with `error`. Both flags hold until the next start.

Top module: `tblscan_top`

## Requirements
- R1: A start pulse, accepted while idle, done or in error, restarts the scan. The first bus read is the word at `baseAddr`.
- R2: If the word at offset 0x00 of a table differs from 0x53445742, the scan stops with `done` and `error` high. No further read is issued.
- R3: The header word at offset 0x04 holds the record count in bits 31:16, the format version in bits 15:8 and the bus type in bits 7:0. A version other than 0x01 or a bus type other than 0x00 stops the scan with `error`.
- R4: Record N of a table starts at table base + 64×N, for N from 1 to count−1; a count of 0 or 1 yields no records. The beat reports that address on `recBase`, and the scan reads no word beyond what each record needs.
- R5: The record type is bits 7:0 of the word at record offset 0x3C. The codes are 0x01 device, 0x02 bridge, 0x80 integrator and 0xFF empty. An empty record produces no beat and costs only that one read.
- R6: The start address is taken big-endian from offsets 0x08 (high word) and 0x0C (low word). The inclusive last address comes from offsets 0x10 and 0x14.
- R7: An integrator record is reported with `recStart` and `recLast` both zero, and without reading its range words.
- R8: A bridge record is reported first. The scan then descends to bridge start + child offset, taken from offsets 0x00 (high word) and 0x04 (low word). It reports the child's records at depth+1 and then resumes the parent at the record after the bridge.
- R9: Once its beat is accepted, a bridge found at depth 4 raises `error`, as does a bridge whose child address exceeds the bus address width. Neither issues a read of the child table.
- R10: While `recValid` is high and `recReady` low, the beat and all its fields hold steady and the scan makes no progress.
- R11: After reset the block is idle with all outputs low. When the top-level table is exhausted it raises `done` with `error` low and holds both until the next start.
- R12: `busReq` stays high with a stable, word-aligned `busAddr` until `busAck`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a scan |
| baseAddr | input | ADDR_W | Address of the top-level table |
| busReq | output | 1 | Read request |
| busAddr | output | ADDR_W | Read address, word aligned |
| busAck | input | 1 | Read acknowledge, data valid |
| busData | input | 32 | Read data, big-endian |
| recValid | output | 1 | Record beat valid |
| recReady | input | 1 | Record beat accepted |
| recType | output | 8 | Record type code |
| recBase | output | ADDR_W | Address of the record |
| recStart | output | 64 | Component start address |
| recLast | output | 64 | Component last address, inclusive |
| recDepth | output | DEPTH_W | Nesting depth, 0 for the top table |
| done | output | 1 | Scan finished |
| error | output | 1 | Scan aborted on a malformed table |

## Verification
The interesting coincidence is the end of a nested table meeting the end of its parent. The pop from the return stack and the top-level completion then resolve back to back. The bench provokes this by making the bridge the last record of the root table. It judges the result by requiring `done` without `error`, the exact total number of reads, and no stray beat after the child's last record. A second collision, a depth-limit bridge whose beat is still pending, is driven by a five-deep bridge chain. Five bridge beats must appear, then `error`, and the read count must show that the sixth table was never touched.

// File: rtl/tblscan_pkg.sv
package tblscan_pkg;
  localparam logic [31:0] MAGIC_WORD = 32'h5344_5742;
  localparam logic [7:0] TYPE_DEV    = 8'h01;
  localparam logic [7:0] TYPE_BRIDGE = 8'h02;
  localparam logic [7:0] TYPE_INTEG  = 8'h80;
  localparam logic [7:0] TYPE_EMPTY  = 8'hFF;

  typedef enum logic [3:0] {
    W_MAGIC, W_HDR, W_TYPE, W_START_HI, W_START_LO,
    W_LAST_HI, W_LAST_LO, W_CHILD_HI, W_CHILD_LO
  } wordSelT;

  typedef struct packed {
    logic    loadRoot;
    logic    capture;
    logic    nextRec;
    logic    push;
    logic    pop;
    wordSelT sel;
  } ctrlStrobeT;

  function automatic logic [5:0] wordOffset(wordSelT s);
    case (s)
      W_HDR, W_CHILD_LO: return 6'h04;
      W_TYPE:            return 6'h3C;
      W_START_HI:        return 6'h08;
      W_START_LO:        return 6'h0C;
      W_LAST_HI:         return 6'h10;
      W_LAST_LO:         return 6'h14;
      default:           return 6'h00;
    endcase
  endfunction
endpackage

// File: rtl/tblscan_dp.sv
module tblscan_dp
  import tblscan_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int MAX_DEPTH = 4,
  parameter int DEPTH_W   = $clog2(MAX_DEPTH + 1)
) (
  input  logic               clk,
  input  logic               rstN,
  input  ctrlStrobeT         strobe,
  input  logic [ADDR_W-1:0]  baseAddr,
  input  logic [31:0]        busData,
  output logic [ADDR_W-1:0]  busAddr,
  output logic               magicHit,
  output logic               hdrGood,
  output logic               moreRecs,
  output logic               atTop,
  output logic               atLimit,
  output logic               childFar,
  output logic [7:0]         curType,
  output logic [ADDR_W-1:0]  recBase,
  output logic [63:0]        recStart,
  output logic [63:0]        recLast,
  output logic [DEPTH_W-1:0] recDepth
);
  localparam int SP_W = (MAX_DEPTH > 1) ? $clog2(MAX_DEPTH) : 1;

  logic [ADDR_W-1:0]  tblBase;
  logic [15:0]        recIdx, recCnt;
  logic [DEPTH_W-1:0] depth;
  logic [7:0]         typeReg;
  logic [63:0]        startReg, lastReg, childReg, childSum;
  logic [ADDR_W-1:0]  stkBase [MAX_DEPTH];
  logic [15:0]        stkIdx  [MAX_DEPTH];
  logic [15:0]        stkCnt  [MAX_DEPTH];
  logic [SP_W-1:0]    pushIdx, popIdx;
  logic [21:0]        recOffset;

  assign recOffset = {recIdx, 6'b0};
  assign recBase   = tblBase + ADDR_W'(recOffset);
  assign busAddr   = recBase + ADDR_W'(wordOffset(strobe.sel));
  assign childSum  = startReg + childReg;
  assign childFar  = |(childSum >> ADDR_W);
  assign pushIdx   = SP_W'(depth);
  assign popIdx    = SP_W'(depth - 1'b1);

  assign magicHit = (busData == MAGIC_WORD);
  assign hdrGood  = (busData[15:8] == 8'h01) && (busData[7:0] == 8'h00);
  assign moreRecs = (recIdx < recCnt);
  assign atTop    = (depth == '0);
  assign atLimit  = (depth == DEPTH_W'(MAX_DEPTH));
  assign curType  = typeReg;
  assign recDepth = depth;
  assign recStart = (typeReg == TYPE_INTEG) ? 64'h0 : startReg;
  assign recLast  = (typeReg == TYPE_INTEG) ? 64'h0 : lastReg;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      tblBase  <= '0;
      recIdx   <= '0;
      recCnt   <= '0;
      depth    <= '0;
      typeReg  <= '0;
      startReg <= '0;
      lastReg  <= '0;
      childReg <= '0;
    end else begin
      if (strobe.loadRoot) begin
        tblBase <= baseAddr;
        recIdx  <= '0;
        recCnt  <= '0;
        depth   <= '0;
      end
      if (strobe.capture) begin
        case (strobe.sel)
          W_HDR: begin
            recCnt <= busData[31:16];
            recIdx <= 16'd1;
          end
          W_TYPE:     typeReg          <= busData[7:0];
          W_START_HI: startReg[63:32]  <= busData;
          W_START_LO: startReg[31:0]   <= busData;
          W_LAST_HI:  lastReg[63:32]   <= busData;
          W_LAST_LO:  lastReg[31:0]    <= busData;
          W_CHILD_HI: childReg[63:32]  <= busData;
          W_CHILD_LO: childReg[31:0]   <= busData;
          default: ;
        endcase
      end
      if (strobe.nextRec) recIdx <= recIdx + 16'd1;
      if (strobe.push) begin
        tblBase <= childSum[ADDR_W-1:0];
        recIdx  <= '0;
        depth   <= depth + 1'b1;
      end
      if (strobe.pop) begin
        tblBase <= stkBase[popIdx];
        recIdx  <= stkIdx[popIdx] + 16'd1;
        recCnt  <= stkCnt[popIdx];
        depth   <= depth - 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (strobe.push) begin
      stkBase[pushIdx] <= tblBase;
      stkIdx[pushIdx]  <= recIdx;
      stkCnt[pushIdx]  <= recCnt;
    end
  end
endmodule

// File: rtl/tblscan_ctrl.sv
module tblscan_ctrl
  import tblscan_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       start,
  input  logic       busAck,
  input  logic       magicHit,
  input  logic       hdrGood,
  input  logic       moreRecs,
  input  logic       atTop,
  input  logic       atLimit,
  input  logic       childFar,
  input  logic [7:0] curType,
  input  logic       recReady,
  output ctrlStrobeT strobe,
  output logic       busReq,
  output logic       recValid,
  output logic       done,
  output logic       error
);
  typedef enum logic [3:0] {
    S_IDLE, S_MAGIC, S_HDR, S_NEXT, S_TYPE, S_DISP, S_SHI, S_SLO,
    S_LHI, S_LLO, S_CHI, S_CLO, S_EMIT, S_DONE, S_ERR
  } stateT;

  stateT state, nxt;

  always_ff @(posedge clk) begin
    if (!rstN) state <= S_IDLE;
    else       state <= nxt;
  end

  assign done  = (state == S_DONE) || (state == S_ERR);
  assign error = (state == S_ERR);

  always_comb begin
    strobe     = '0;
    strobe.sel = W_MAGIC;
    busReq     = 1'b0;
    recValid   = 1'b0;
    nxt        = state;
    case (state)
      S_IDLE, S_DONE, S_ERR: begin
        if (start) begin
          strobe.loadRoot = 1'b1;
          nxt = S_MAGIC;
        end
      end
      S_MAGIC: begin
        busReq = 1'b1;
        if (busAck) nxt = magicHit ? S_HDR : S_ERR;
      end
      S_HDR: begin
        busReq = 1'b1;
        strobe.sel = W_HDR;
        if (busAck) begin
          strobe.capture = 1'b1;
          nxt = hdrGood ? S_NEXT : S_ERR;
        end
      end
      S_NEXT: begin
        if (moreRecs)   nxt = S_TYPE;
        else if (atTop) nxt = S_DONE;
        else            strobe.pop = 1'b1;
      end
      S_TYPE: begin
        busReq = 1'b1;
        strobe.sel = W_TYPE;
        if (busAck) begin
          strobe.capture = 1'b1;
          nxt = S_DISP;
        end
      end
      S_DISP: begin
        if (curType == TYPE_EMPTY) begin
          strobe.nextRec = 1'b1;
          nxt = S_NEXT;
        end else if (curType == TYPE_INTEG) begin
          nxt = S_EMIT;
        end else begin
          nxt = S_SHI;
        end
      end
      S_SHI, S_SLO, S_LHI, S_LLO, S_CHI, S_CLO: begin
        busReq = 1'b1;
        case (state)
          S_SHI:   strobe.sel = W_START_HI;
          S_SLO:   strobe.sel = W_START_LO;
          S_LHI:   strobe.sel = W_LAST_HI;
          S_LLO:   strobe.sel = W_LAST_LO;
          S_CHI:   strobe.sel = W_CHILD_HI;
          default: strobe.sel = W_CHILD_LO;
        endcase
        if (busAck) begin
          strobe.capture = 1'b1;
          case (state)
            S_SHI:   nxt = S_SLO;
            S_SLO:   nxt = S_LHI;
            S_LHI:   nxt = S_LLO;
            S_LLO:   nxt = (curType == TYPE_BRIDGE) ? S_CHI : S_EMIT;
            S_CHI:   nxt = S_CLO;
            default: nxt = S_EMIT;
          endcase
        end
      end
      S_EMIT: begin
        recValid = 1'b1;
        if (recReady) begin
          if (curType == TYPE_BRIDGE) begin
            if (atLimit || childFar) nxt = S_ERR;
            else begin
              strobe.push = 1'b1;
              nxt = S_MAGIC;
            end
          end else begin
            strobe.nextRec = 1'b1;
            nxt = S_NEXT;
          end
        end
      end
      default: nxt = S_IDLE;
    endcase
  end
endmodule

// File: rtl/tblscan_top.sv
module tblscan_top
  import tblscan_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int MAX_DEPTH = 4,
  parameter int DEPTH_W   = $clog2(MAX_DEPTH + 1)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               start,
  input  logic [ADDR_W-1:0]  baseAddr,
  output logic               busReq,
  output logic [ADDR_W-1:0]  busAddr,
  input  logic               busAck,
  input  logic [31:0]        busData,
  output logic               recValid,
  input  logic               recReady,
  output logic [7:0]         recType,
  output logic [ADDR_W-1:0]  recBase,
  output logic [63:0]        recStart,
  output logic [63:0]        recLast,
  output logic [DEPTH_W-1:0] recDepth,
  output logic               done,
  output logic               error
);
  ctrlStrobeT strobe;
  logic magicHit, hdrGood, moreRecs, atTop, atLimit, childFar;

  tblscan_ctrl ctrl_i (
    .clk(clk), .rstN(rstN), .start(start), .busAck(busAck),
    .magicHit(magicHit), .hdrGood(hdrGood), .moreRecs(moreRecs),
    .atTop(atTop), .atLimit(atLimit), .childFar(childFar),
    .curType(recType), .recReady(recReady), .strobe(strobe),
    .busReq(busReq), .recValid(recValid), .done(done), .error(error)
  );

  tblscan_dp #(.ADDR_W(ADDR_W), .MAX_DEPTH(MAX_DEPTH), .DEPTH_W(DEPTH_W)) dp_i (
    .clk(clk), .rstN(rstN), .strobe(strobe), .baseAddr(baseAddr),
    .busData(busData), .busAddr(busAddr), .magicHit(magicHit),
    .hdrGood(hdrGood), .moreRecs(moreRecs), .atTop(atTop),
    .atLimit(atLimit), .childFar(childFar), .curType(recType),
    .recBase(recBase), .recStart(recStart), .recLast(recLast),
    .recDepth(recDepth)
  );
endmodule

// File: rtl/tblscan_chk.sv
module tblscan_chk #(
  parameter int ADDR_W    = 32,
  parameter int MAX_DEPTH = 4,
  parameter int DEPTH_W   = 3
) (
  input logic               clk,
  input logic               rstN,
  input logic               busReq,
  input logic [ADDR_W-1:0]  busAddr,
  input logic               busAck,
  input logic               recValid,
  input logic               recReady,
  input logic [7:0]         recType,
  input logic [63:0]        recStart,
  input logic [63:0]        recLast,
  input logic [DEPTH_W-1:0] recDepth,
  input logic               done,
  input logic               error
);
  AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rstN)
    busReq && !busAck |=> busReq && $stable(busAddr)); // R12
  AST_ADDR_ALIGNED: assert property (@(posedge clk) disable iff (!rstN)
    busReq |-> busAddr[1:0] == 2'b00); // R12
  AST_BEAT_HELD: assert property (@(posedge clk) disable iff (!rstN)
    recValid && !recReady |=> recValid && $stable(recType) && $stable(recStart)
    && $stable(recLast) && $stable(recDepth)); // R10
  AST_STALL_NO_READ: assert property (@(posedge clk) disable iff (!rstN)
    recValid |-> !busReq); // R10
  AST_INTEG_NO_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    recValid && recType == 8'h80 |-> recStart == 64'h0 && recLast == 64'h0); // R7
  AST_DEPTH_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    recValid |-> int'(recDepth) <= MAX_DEPTH); // R9
  AST_ERROR_IMPLIES_DONE: assert property (@(posedge clk) disable iff (!rstN)
    error |-> done); // R2
  AST_QUIET_WHEN_DONE: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !busReq && !recValid); // R11
  AST_NO_EMPTY_BEAT: assert property (@(posedge clk) disable iff (!rstN)
    recValid |-> recType != 8'hFF); // R5
endmodule

bind tblscan_top tblscan_chk #(.ADDR_W(ADDR_W), .MAX_DEPTH(MAX_DEPTH), .DEPTH_W(DEPTH_W)) chk_i (
  .clk(clk), .rstN(rstN), .busReq(busReq), .busAddr(busAddr), .busAck(busAck),
  .recValid(recValid), .recReady(recReady), .recType(recType),
  .recStart(recStart), .recLast(recLast), .recDepth(recDepth),
  .done(done), .error(error)
);

// File: tb/tblscan_top_tb_top.sv
module tblscan_top_tb_top;
  typedef struct packed {
    logic [7:0]  typ;
    logic [31:0] base;
    logic [63:0] st;
    logic [63:0] lst;
    logic [2:0]  dep;
  } expT;

  // Expected beats of the main scan: root table at 0x000, child table at 0x300
  localparam expT EXP [4] = '{
    '{8'h01, 32'h040, 64'h1000, 64'h1FFF, 3'd0},
    '{8'h02, 32'h0C0, 64'h0200, 64'h03FF, 3'd0},
    '{8'h80, 32'h340, 64'h0, 64'h0, 3'd1},
    '{8'h01, 32'h380, 64'h00AB_0000_0000_0010, 64'h00AB_0000_0000_001F, 3'd1}
  };

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic start = 1'b0;
  logic [31:0] baseAddr = '0;
  logic busReq, busAck = 1'b0;
  logic [31:0] busAddr, busData = '0;
  logic recValid, recReady = 1'b0;
  logic [7:0] recType;
  logic [31:0] recBase;
  logic [63:0] recStart, recLast;
  logic [2:0] recDepth;
  logic done, error;

  logic [31:0] mem [512];
  int readCnt = 0;
  logic armed = 1'b0;
  logic [31:0] firstAddr = '0;
  int total = 0, failed = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  tblscan_top dut_i (
    .clk(clk), .rstN(rstN), .start(start), .baseAddr(baseAddr),
    .busReq(busReq), .busAddr(busAddr), .busAck(busAck), .busData(busData),
    .recValid(recValid), .recReady(recReady), .recType(recType),
    .recBase(recBase), .recStart(recStart), .recLast(recLast),
    .recDepth(recDepth), .done(done), .error(error)
  );

  always @(posedge clk) begin
    busAck  <= busReq && !busAck;
    busData <= mem[busAddr[10:2]];
    if (rstN && busReq && busAck) readCnt <= readCnt + 1;
    if (start) armed <= 1'b1;
    else if (armed && busReq && busAck) begin
      firstAddr <= busAddr;
      armed <= 1'b0;
    end
  end

  task automatic check(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
    total++;
    if (!ok) begin
      failed++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic putW(input int a, input logic [31:0] d);
    mem[a >> 2] = d;
  endtask

  task automatic putHdr(input int a, input logic [15:0] cnt, input logic [7:0] ver,
                        input logic [7:0] bt);
    putW(a, 32'h5344_5742);
    putW(a + 4, {cnt, ver, bt});
  endtask

  task automatic putRec(input int a, input logic [7:0] t, input logic [63:0] child,
                        input logic [63:0] st, input logic [63:0] lst);
    putW(a, child[63:32]);        putW(a + 4, child[31:0]);
    putW(a + 8, st[63:32]);       putW(a + 12, st[31:0]);
    putW(a + 16, lst[63:32]);     putW(a + 20, lst[31:0]);
    putW(a + 60, {24'h0, t});
  endtask

  task automatic kick(input logic [31:0] a);
    @(negedge clk);
    baseAddr = a;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic waitBeat(output bit got);
    got = 0;
    for (int i = 0; i < 300; i++) begin
      if (recValid) begin got = 1; break; end
      if (done) break;
      @(negedge clk);
    end
  endtask

  task automatic accept();
    recReady = 1'b1;
    @(negedge clk);
    recReady = 1'b0;
  endtask

  task automatic waitDone();
    for (int i = 0; i < 300; i++) begin
      if (done || recValid) break;
      @(negedge clk);
    end
  endtask

  initial begin
    #(8 * 150000);
    if (!finished) begin
      failed++;
      total++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("%0d/%0d checks passed", total - failed, total);
      $finish;
    end
  end

  initial begin
    int snap;
    bit got;
    for (int i = 0; i < 512; i++) mem[i] = 32'h0;
    // Main root table, bridge last so the child end meets the root end
    putHdr(32'h000, 16'd4, 8'h01, 8'h00);
    putRec(32'h040, 8'h01, 64'h0, 64'h1000, 64'h1FFF);
    putRec(32'h080, 8'hFF, 64'h0, 64'h5555, 64'h6666);
    putRec(32'h0C0, 8'h02, 64'h100, 64'h200, 64'h3FF);
    putHdr(32'h300, 16'd3, 8'h01, 8'h00);
    putRec(32'h340, 8'h80, 64'h0, 64'hDEAD, 64'hBEEF);
    putRec(32'h380, 8'h01, 64'h0, 64'h00AB_0000_0000_0010, 64'h00AB_0000_0000_001F);
    // Five-deep chain of bridges at 0x400, step 0x80
    for (int k = 0; k < 5; k++) begin
      putHdr(32'h400 + 32'h80 * k, 16'd2, 8'h01, 8'h00);
      putRec(32'h440 + 32'h80 * k, 8'h02, 64'(32'h480 + 32'h80 * k), 64'h0, 64'hF);
    end
    putW(32'h680, 32'h5344_5741);                 // wrong magic
    putW(32'h6C0, 32'h5344_5742); putW(32'h6C4, {16'd3, 8'h02, 8'h00}); // wrong version
    putW(32'h700, 32'h5344_5742); putW(32'h704, {16'd3, 8'h01, 8'h03}); // wrong bus type
    putHdr(32'h740, 16'd1, 8'h01, 8'h00);         // header only

    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R11: reset state
    check(!busReq && !recValid && !done && !error, "R11 reset idle",
          {busReq, recValid, done, error}, 0);

    // Main scan, table-driven
    snap = readCnt;
    kick(32'h000);
    for (int i = 0; i < 4; i++) begin
      waitBeat(got);
      check(got, "R4 beat present", 64'(got), 1);
      if (i == 0) check(firstAddr == 32'h0, "R1 first read at base", firstAddr, 0);
      check(recType == EXP[i].typ, "R5 type", recType, EXP[i].typ);
      check(recBase == EXP[i].base, "R4 record base", recBase, EXP[i].base);
      check(recStart == EXP[i].st, "R6 start", recStart, EXP[i].st);
      check(recLast == EXP[i].lst, "R6 last", recLast, EXP[i].lst);
      check(recDepth == EXP[i].dep, "R8 depth", recDepth, EXP[i].dep);
      if (EXP[i].typ == 8'h80)
        check(recStart == 0 && recLast == 0, "R7 integrator range zero", recStart, 0);
      repeat (3) @(negedge clk);
      check(recValid && recStart == EXP[i].st && recType == EXP[i].typ,
            "R10 beat held while stalled", recStart, EXP[i].st);
      accept();
    end
    waitDone();
    check(done && !error && !recValid, "R11 done after nested end", {done, error, recValid}, 3'b100);
    check(readCnt - snap == 23, "R4 R5 R7 R8 read count", readCnt - snap, 23);
    repeat (5) @(negedge clk);
    check(done && !error && !busReq, "R11 done holds", {done, error, busReq}, 3'b100);

    // Bad magic
    snap = readCnt;
    kick(32'h680);
    waitDone();
    check(done && error, "R2 magic mismatch error", {done, error}, 2'b11);
    check(readCnt - snap == 1, "R2 single read", readCnt - snap, 1);
    check(firstAddr == 32'h680, "R1 first read at base", firstAddr, 32'h680);

    // Bad version, bad bus type
    snap = readCnt;
    kick(32'h6C0);
    waitDone();
    check(done && error && readCnt - snap == 2, "R3 version rejected", readCnt - snap, 2);
    snap = readCnt;
    kick(32'h700);
    waitDone();
    check(done && error && readCnt - snap == 2, "R3 bus type rejected", readCnt - snap, 2);

    // Header-only table
    snap = readCnt;
    kick(32'h740);
    waitDone();
    check(done && !error && readCnt - snap == 2, "R4 count of one gives no records",
          readCnt - snap, 2);

    // Depth limit
    snap = readCnt;
    kick(32'h400);
    for (int k = 0; k < 5; k++) begin
      waitBeat(got);
      check(got && recType == 8'h02 && recDepth == 3'(k), "R9 chain bridge beat",
            {56'h0, 5'h0, recDepth}, k);
      check(recBase == 32'h440 + 32'h80 * k, "R8 bridge base", recBase, 32'h440 + 32'h80 * k);
      accept();
    end
    waitDone();
    check(done && error, "R9 depth overflow error", {done, error}, 2'b11);
    check(readCnt - snap == 45, "R9 no read of sixth table", readCnt - snap, 45);

    finished = 1;
    $display("%0d/%0d checks passed", total - failed, total);
    $finish;
  end
endmodule